// File: doc/BRIEF.md
# Three-Level Vectored Interrupt Arbiter

This block sits between a set of interrupt request sources and a processor core. Sixteen request sources are folded onto ten interrupt vectors, with several sources sharing one vector. Each vector is assigned one of three priority levels. The arbiter remembers which levels are currently being serviced. It selects the best pending vector that is allowed to interrupt the running code, and offers its entry address to the core.

The offer is a valid/ready handshake. `irq_valid` rises with a registered `irq_addr` and `irq_level`. All three are held unchanged until the core raises `irq_ready`, even if the request that caused the offer goes away in the meantime. A cycle with `irq_valid` and `irq_ready` both high is an acceptance. The accepted level is pushed onto the in-service stack, and the offer is dropped for that cycle. The core then pulses `irq_ret` when the handler returns, which pops the stack. Source flags are cleared by the core through its own path; the arbiter never touches them.

Top module: `irq_level_arbiter`

## Requirements
- R1: After reset, `irq_valid` is 0 and `cur_level` is 0 (nothing in service).
- R2: A vector is pending when at least one of its sources has both `src_flag` and `src_en` set. With the default map, sources 0..15 belong to vectors 0,1,2,2,2,3,3,4,4,5,5,6,7,8,8,8 in that order, and vector 9 has no source.
- R3: Level codes are 0 none, 1 low, 2 high, 3 top. `vec_hi[v]`=0 gives vector v level 1. `vec_hi[v]`=1 gives level 3 for vectors 0 and 1, and level 2 for vectors 2..9. A vector 2..9 never reaches level 3.
- R4: Among eligible pending vectors, the one with the highest level is offered.
- R5: Among eligible pending vectors of the same level, the one with the smallest index is offered.
- R6: `irq_addr` equals 3 + 8 × vector index, so 0x03 for vector 0 up to 0x4B for vector 9.
- R7: A vector is eligible only if its level is strictly greater than `cur_level`. A request at or below the level in service is not offered.
- R8: While `irq_valid` is 1 and `irq_ready` is 0, `irq_valid`, `irq_addr` and `irq_level` stay unchanged, even when the request is withdrawn.
- R9: On a cycle with `irq_valid` and `irq_ready` both high, `irq_valid` is 0 in the next cycle and `cur_level` becomes the accepted level.
- R10: `irq_ret` pops one level and restores the previous `cur_level`. It is ignored when nothing is in service, and ignored in a cycle where an offer is accepted.
- R11: `irq_ready` while `irq_valid` is 0 has no effect on `cur_level` or on later offers.
- R12: When no offer is open and an eligible vector is pending at a clock edge, `irq_valid` is 1 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_flag | input | 16 | Per-source request flags |
| src_en | input | 16 | Per-source enables |
| vec_hi | input | 10 | Per-vector level select (0 low, 1 upper level) |
| irq_ready | input | 1 | Core accepts the current offer |
| irq_ret | input | 1 | Handler return, pops one in-service level |
| irq_valid | output | 1 | An offer is open |
| irq_addr | output | 8 | Entry address of the offered vector |
| irq_level | output | 2 | Level of the offered vector |
| cur_level | output | 2 | Highest level now in service (0 when idle) |

## Verification
The assertions take for granted that `irq_ret` is only meaningful as a handler return. They also assume the core accepts offers only through `irq_ready` while `irq_valid` is high. Under that assumption the pushed level is always strictly above the level in service, so three stack entries are enough. The stimulus draws flags, enables, level selects, ready and return pulses freely. This includes returns with an empty stack, ready without an offer, and return together with acceptance. Nesting therefore never exceeds the three levels, and every out-of-turn pulse lands in the cases the requirements say are ignored.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam logic [1:0] LV_NONE = 2'd0;
  localparam logic [1:0] LV_LOW  = 2'd1;
  localparam logic [1:0] LV_HIGH = 2'd2;
  localparam logic [1:0] LV_TOP  = 2'd3;

  localparam int ADDR_W    = 8;
  localparam int VEC_BASE  = 3;
  localparam int VEC_SHIFT = 3;
endpackage

// File: rtl/irq_vec_gather.sv
module irq_vec_gather #(
  parameter int N_SRC = 16,
  parameter int N_VEC = 10,
  parameter int IDX_W = 4,
  parameter logic [N_SRC*IDX_W-1:0] SRC_MAP = '0
) (
  input  logic [N_SRC-1:0] flag,
  input  logic [N_SRC-1:0] en,
  output logic [N_VEC-1:0] pend
);
  for (genvar v = 0; v < N_VEC; v++) begin : g_vec
    logic [N_SRC-1:0] hit;
    for (genvar s = 0; s < N_SRC; s++) begin : g_src
      assign hit[s] = flag[s] & en[s] &
                      (SRC_MAP[s*IDX_W +: IDX_W] == IDX_W'(v));
    end
    assign pend[v] = |hit;
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_arb_pkg::*;
#(
  parameter int N_VEC = 10,
  parameter int N_TOP = 2,
  parameter int IDX_W = 4
) (
  input  logic [N_VEC-1:0] pend,
  input  logic [N_VEC-1:0] vec_hi,
  input  logic [1:0]       cur,
  output logic             found,
  output logic [IDX_W-1:0] idx,
  output logic [1:0]       lvl
);
  always_comb begin
    logic [1:0] lv;
    lv    = LV_NONE;
    idx   = '0;
    lvl   = LV_NONE;
    // scan from the top index down; ">=" lets a lower index take a tie
    for (int v = N_VEC - 1; v >= 0; v--) begin
      if (vec_hi[v]) lv = (v < N_TOP) ? LV_TOP : LV_HIGH;
      else           lv = LV_LOW;
      if (pend[v] && (lv > cur) && (lv >= lvl)) begin
        lvl = lv;
        idx = IDX_W'(v);
      end
    end
    found = (lvl != LV_NONE);
  end
endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack
  import irq_arb_pkg::*;
#(
  parameter int NEST = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic [1:0] push_lvl,
  input  logic       pop,
  output logic [1:0] cur
);
  localparam int DPW = $clog2(NEST + 1);

  logic [1:0]     stk [NEST];
  logic [DPW-1:0] depth;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth <= '0;
      for (int i = 0; i < NEST; i++) stk[i] <= LV_NONE;
    end else if (push && depth != DPW'(NEST)) begin
      for (int i = 0; i < NEST; i++)
        if (DPW'(i) == depth) stk[i] <= push_lvl;
      depth <= depth + 1'b1;
    end else if (pop && depth != '0) begin
      depth <= depth - 1'b1;
    end
  end

  always_comb begin
    cur = LV_NONE;
    for (int i = 0; i < NEST; i++)
      if (DPW'(i + 1) == depth) cur = stk[i];
  end

  // R9: an accepted level becomes the level in service
  p_push_lvl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && depth != DPW'(NEST)) |=> (cur == $past(push_lvl)));

  // R7: only a strictly higher level may nest
  p_nest_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (push_lvl > cur));

  // R10: a return with nothing in service leaves the stack empty
  p_pop_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && depth == '0) |=> (depth == '0 && cur == LV_NONE));
endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter
  import irq_arb_pkg::*;
#(
  parameter int N_SRC = 16,
  parameter int N_VEC = 10,
  parameter int N_TOP = 2,
  parameter int IDX_W = 4,
  parameter int NEST  = 3,
  parameter logic [N_SRC*IDX_W-1:0] SRC_MAP = 64'h8887_6554_4332_2210
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_flag,
  input  logic [N_SRC-1:0]  src_en,
  input  logic [N_VEC-1:0]  vec_hi,
  input  logic              irq_ready,
  input  logic              irq_ret,
  output logic              irq_valid,
  output logic [ADDR_W-1:0] irq_addr,
  output logic [1:0]        irq_level,
  output logic [1:0]        cur_level
);
  logic [N_VEC-1:0] pend;
  logic             win_found;
  logic [IDX_W-1:0] win_idx;
  logic [1:0]       win_lvl;
  logic             take;

  irq_vec_gather #(
    .N_SRC(N_SRC), .N_VEC(N_VEC), .IDX_W(IDX_W), .SRC_MAP(SRC_MAP)
  ) u_gather (
    .flag(src_flag), .en(src_en), .pend(pend)
  );

  irq_pick #(
    .N_VEC(N_VEC), .N_TOP(N_TOP), .IDX_W(IDX_W)
  ) u_pick (
    .pend(pend), .vec_hi(vec_hi), .cur(cur_level),
    .found(win_found), .idx(win_idx), .lvl(win_lvl)
  );

  assign take = irq_valid & irq_ready;

  irq_level_stack #(.NEST(NEST)) u_stack (
    .clk(clk), .rst_n(rst_n),
    .push(take), .push_lvl(irq_level),
    .pop(irq_ret & ~take),
    .cur(cur_level)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_valid <= 1'b0;
      irq_addr  <= '0;
      irq_level <= LV_NONE;
    end else if (take) begin
      irq_valid <= 1'b0;
    end else if (!irq_valid && win_found) begin
      irq_valid <= 1'b1;
      irq_addr  <= ADDR_W'(VEC_BASE) + (ADDR_W'(win_idx) << VEC_SHIFT);
      irq_level <= win_lvl;
    end
  end

  // R8: an open offer is frozen until accepted
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_ready) |=>
      (irq_valid && $stable(irq_addr) && $stable(irq_level)));

  // R9: acceptance closes the offer
  p_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ready) |=> !irq_valid);

  // R7: an offer is always above the level in service
  p_above_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_level > cur_level));

  // R6: entry addresses sit on the 8-byte grid at offset 3
  p_addr_grid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_addr[2:0] == 3'd3 &&
                   irq_addr < ADDR_W'(VEC_BASE + 8 * N_VEC)));
endmodule

// File: tb/irq_level_arbiter_test.sv
module irq_level_arbiter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src_flag = '0;
  logic [15:0] src_en = '0;
  logic [9:0]  vec_hi = '0;
  logic        irq_ready = 1'b0;
  logic        irq_ret = 1'b0;
  logic        irq_valid;
  logic [7:0]  irq_addr;
  logic [1:0]  irq_level;
  logic [1:0]  cur_level;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_level_arbiter uut (
    .clk(clk), .rst_n(rst_n), .src_flag(src_flag), .src_en(src_en),
    .vec_hi(vec_hi), .irq_ready(irq_ready), .irq_ret(irq_ret),
    .irq_valid(irq_valid), .irq_addr(irq_addr), .irq_level(irq_level),
    .cur_level(cur_level)
  );

  // reference state
  logic [1:0] m_stk [3];
  int         m_dep = 0;
  bit         m_valid = 0;
  int         m_addr = 0;
  int         m_lvl = 0;

  // R2: default source-to-vector map
  function automatic int src_vec(int s);
    case (s)
      0: return 0;   1: return 1;
      2, 3, 4: return 2;
      5, 6: return 3;
      7, 8: return 4;
      9, 10: return 5;
      11: return 6;  12: return 7;
      default: return 8;
    endcase
  endfunction

  // R3: level of a vector from its select bit
  function automatic int lvl_of(logic [9:0] h, int v);
    if (!h[v]) return 1;
    return (v < 2) ? 3 : 2;
  endfunction

  function automatic int m_cur();
    return (m_dep == 0) ? 0 : int'(m_stk[m_dep-1]);
  endfunction

  task automatic model_step(input logic [15:0] f, input logic [15:0] e,
                            input logic [9:0] h, input bit rdy, input bit ret);
    int cur = m_cur();
    int best = -1;
    int bl = 0;
    bit take;
    for (int v = 0; v < 10; v++) begin
      bit p = 0;
      for (int s = 0; s < 16; s++)
        if (f[s] && e[s] && src_vec(s) == v) p = 1;
      if (p && lvl_of(h, v) > cur && lvl_of(h, v) > bl) begin
        best = v;
        bl = lvl_of(h, v);
      end
    end
    take = m_valid && rdy;
    if (take) begin
      if (m_dep < 3) begin
        m_stk[m_dep] = 2'(m_lvl);
        m_dep++;
      end
      m_valid = 0;
    end else begin
      if (ret && m_dep > 0) m_dep--;
      if (!m_valid && best >= 0) begin
        m_valid = 1;
        m_addr  = 3 + 8 * best;
        m_lvl   = bl;
      end
    end
  endtask

  task automatic chk(input string tag, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk({tag, " valid"}, int'(irq_valid), int'(m_valid));
    if (m_valid) begin
      chk({tag, " addr"}, int'(irq_addr), m_addr);
      chk({tag, " level"}, int'(irq_level), m_lvl);
    end
    chk({tag, " cur_level"}, int'(cur_level), m_cur());
  endtask

  // called at a falling edge: drive, predict, let one rising edge pass, compare
  task automatic cyc(input logic [15:0] f, input logic [15:0] e,
                     input logic [9:0] h, input bit rdy, input bit ret,
                     input string tag);
    src_flag = f; src_en = e; vec_hi = h; irq_ready = rdy; irq_ret = ret;
    model_step(f, e, h, rdy, ret);
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 3; i++) m_stk[i] = 2'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1
    chk("R1 valid after reset", int'(irq_valid), 0);
    chk("R1 cur_level after reset", int'(cur_level), 0);

    // R12 R2 R6: source 3 -> vector 2, low
    cyc(16'h0008, 16'h0008, 10'h000, 0, 0, "R12");
    chk("R12 offer raised", int'(irq_valid), 1);
    chk("R6 addr vector 2", int'(irq_addr), 'h13);
    chk("R2 shared vector level", int'(irq_level), 1);
    // R2: flag without enable does nothing
    // R8: withdraw the request; offer is held
    cyc(16'h0000, 16'h0008, 10'h000, 0, 0, "R8");
    chk("R8 held valid", int'(irq_valid), 1);
    chk("R8 held addr", int'(irq_addr), 'h13);
    // R9
    cyc(16'h0000, 16'h0008, 10'h000, 1, 0, "R9");
    chk("R9 offer closed", int'(irq_valid), 0);
    chk("R9 level in service", int'(cur_level), 1);
    // R10
    cyc(16'h0000, 16'h0000, 10'h000, 0, 1, "R10");
    chk("R10 popped to idle", int'(cur_level), 0);
    cyc(16'h0000, 16'h0000, 10'h000, 0, 1, "R10 empty");
    chk("R10 pop on empty ignored", int'(cur_level), 0);
    // R11
    cyc(16'h0000, 16'h0000, 10'h000, 1, 0, "R11");
    chk("R11 ready without offer", int'(cur_level), 0);
    chk("R11 no offer", int'(irq_valid), 0);
    cyc(16'h0001, 16'h0000, 10'h000, 0, 0, "R2 disabled");
    chk("R2 flag without enable", int'(irq_valid), 0);

    // R5: vectors 4 and 6 both low
    cyc(16'h0880, 16'hFFFF, 10'h000, 0, 0, "R5");
    chk("R5 lowest index wins", int'(irq_addr), 'h23);
    cyc(16'h0880, 16'hFFFF, 10'h000, 1, 0, "R5 accept");
    // R7: vector 6 low while low is in service
    cyc(16'h0800, 16'hFFFF, 10'h000, 0, 0, "R7");
    chk("R7 equal level not offered", int'(irq_valid), 0);
    cyc(16'h0000, 16'hFFFF, 10'h000, 0, 1, "R7 return");
    cyc(16'h0000, 16'hFFFF, 10'h000, 0, 0, "R7 idle");

    // R4: vector 7 high beats vector 3 low
    cyc(16'h1020, 16'hFFFF, 10'h080, 0, 0, "R4");
    chk("R4 higher level wins", int'(irq_addr), 'h3B);
    chk("R4 level high", int'(irq_level), 2);
    cyc(16'h0000, 16'hFFFF, 10'h080, 1, 0, "R4 accept");
    // R3: vector 2 with select set is high, not top: no nesting over high
    cyc(16'h0008, 16'hFFFF, 10'h084, 0, 0, "R3");
    chk("R3 vector 2 capped at high", int'(irq_valid), 0);
    // R3 R7: vector 1 with select set is top and nests
    cyc(16'h000A, 16'hFFFF, 10'h086, 0, 0, "R3 top");
    chk("R3 vector 1 top addr", int'(irq_addr), 'h0B);
    chk("R3 vector 1 top level", int'(irq_level), 3);
    // R10: return in the same cycle as acceptance is ignored
    cyc(16'h0000, 16'hFFFF, 10'h086, 1, 1, "R10 with accept");
    chk("R10 accept wins over return", int'(cur_level), 3);
    for (int i = 0; i < 4; i++)
      cyc(16'h0000, 16'hFFFF, 10'h000, 0, 1, "R10 unwind");
    chk("R10 unwound", int'(cur_level), 0);

    // random mix
    for (int n = 0; n < 5000; n++) begin
      logic [15:0] f, e;
      logic [9:0]  h;
      bit rdy, ret;
      f   = 16'($urandom & $urandom & $urandom);
      e   = 16'($urandom | $urandom);
      h   = 10'($urandom);
      rdy = ($urandom % 3) == 0;
      ret = ($urandom % 6) == 0;
      cyc(f, e, h, rdy, ret, "R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 R12 random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule